// File: doc/BRIEF.md
# Monotone Propagation Lattice Checker

This block decides whether a fixed system of sparse Boolean equations is inconsistent under a chosen assignment of a few variables. Each candidate solution vector of each equation is a horizontal node. Each agreement tuple, made of a list of vectors from one equation and a list from a neighbouring equation, gives two vertical nodes. The first vertical node is controlled by the first list and drives the second list. The second vertical node has the roles swapped. A marked horizontal node means its vector cannot be part of any common solution. Marks only grow, one switch step per clock, until nothing more changes.

All wiring is fixed by parameters. A tuple's sides, each equation's membership and the vectors that each guess drives are given as bit masks, where bit `t*NUM_VEC+v` refers to vector `v`. To use the block, the surrounding logic pulses `clear`, applies a guess, and holds `run` high. It then waits for `settled` and reads `inconsistent`. `steps` reports how deep the propagation went. `switch_count` gives the cost of the same lattice built from physical switches.

Top module: `prop_lattice`

## Requirements
- R1: Reset, and a synchronous `clear` (which wins over `run`), zero all marks and all vertical nodes, zero `steps` and drop `settled`, so `marked` reads 0 on the cycle after.
- R2: A horizontal node becomes marked on the clock edge after any vertical node that drives it is active, or after a guess drives it. This is an OR over its drivers.
- R3: A vertical node becomes active on the clock edge after every vector on its controlling side is marked. This is an AND over its controllers. A vertical node whose controlling side is empty turns active on the first edge with `run` high.
- R4: Tuple `t` takes its sides from `TUP_A[t*NUM_VEC +: NUM_VEC]` and `TUP_B[t*NUM_VEC +: NUM_VEC]`. The A-controlled node drives the B vectors, and the B-controlled node drives the A vectors.
- R5: With `guess_en[g]` and `run` high, `guess_val[g]`=0 drives the vectors in `G_ONE` slice `g` (variable is 1), and `guess_val[g]`=1 drives the vectors in `G_ZERO` slice `g`. With `guess_en` low, no guess marks anything.
- R6: Marks and vertical activations never fall except through `clear`, and with `run` low nothing changes.
- R7: `inconsistent` is high exactly while, for some equation `e`, every vector in its membership slice `EQ_MEMB[e*NUM_VEC +: NUM_VEC]` is marked.
- R8: `settled` is high on the cycle after an edge taken with `run` high at which no horizontal or vertical node changed.
- R9: `steps` counts the `run` edges since the last clear at which at least one node changed, saturating at its maximum.
- R10: `switch_count` equals twice the total number of vectors over all tuple sides, plus, for each guess, the number of vectors of its equation. For the default three-equation lattice this is 34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all marks and counters |
| run | input | 1 | Enables one propagation step per clock |
| guess_en | input | NUM_GUESS | Enables each guessed variable |
| guess_val | input | NUM_GUESS | Guessed value of each variable |
| marked | output | NUM_VEC | One bit per vector: excluded from any solution |
| inconsistent | output | 1 | Some equation has every vector marked |
| settled | output | 1 | Last enabled step changed no node |
| steps | output | STEP_W | Enabled steps that changed a node since clear |
| switch_count | output | SW_W | Switch cost of the equivalent lattice |

## Verification
A wrong vertical or horizontal state shows on `marked` within two edges, because each vertical node feeds a vector on the very next step. Checking the mark set edge by edge therefore exposes an OR/AND swap or a mirrored tuple role at the cycle where it happens. A missed or extra change shifts `steps` and moves the edge where `settled` rises, so both are compared to hand-derived counts. The final mark set is also compared against a marking that the bench computes by plain tuple agreement, for both values of the guess. An empty-sided tuple lattice shows whether propagation starts with no guess at all.

// File: rtl/prop_lattice.sv
module prop_lattice #(
  parameter int NUM_VEC   = 8,
  parameter int NUM_EQ    = 3,
  parameter int NUM_TUP   = 7,
  parameter int NUM_GUESS = 1,
  parameter int STEP_W    = 8,
  parameter logic [NUM_TUP*NUM_VEC-1:0]   TUP_A   = 56'h04_02_01_10_08_04_03,
  parameter logic [NUM_TUP*NUM_VEC-1:0]   TUP_B   = 56'h40_80_20_A0_40_10_08,
  parameter logic [NUM_EQ*NUM_VEC-1:0]    EQ_MEMB = 24'hE0_18_07,
  parameter logic [NUM_GUESS*NUM_VEC-1:0] G_ONE   = 8'h08,
  parameter logic [NUM_GUESS*NUM_VEC-1:0] G_ZERO  = 8'h10,
  localparam int SW_W = $clog2(2*NUM_TUP*NUM_VEC + NUM_GUESS*NUM_VEC + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 run,
  input  logic [NUM_GUESS-1:0] guess_en,
  input  logic [NUM_GUESS-1:0] guess_val,
  output logic [NUM_VEC-1:0]   marked,
  output logic                 inconsistent,
  output logic                 settled,
  output logic [STEP_W-1:0]    steps,
  output logic [SW_W-1:0]      switch_count
);

  function automatic int count_switches();
    int n;
    n = 0;
    for (int i = 0; i < NUM_TUP*NUM_VEC; i++)
      n += 2 * (int'(TUP_A[i]) + int'(TUP_B[i]));
    for (int i = 0; i < NUM_GUESS*NUM_VEC; i++)
      n += int'(G_ONE[i] | G_ZERO[i]);
    return n;
  endfunction

  localparam int SWITCHES = count_switches();

  logic [NUM_VEC-1:0] h_q, h_d, tup_drv, g_drv;
  logic [NUM_TUP-1:0] vab_q, vab_d, vba_q, vba_d;
  logic [NUM_TUP-1:0][NUM_VEC-1:0] tdrv;
  logic [NUM_EQ-1:0] eq_full;
  logic changed;

  for (genvar t = 0; t < NUM_TUP; t++) begin : g_tup
    localparam logic [NUM_VEC-1:0] AM = TUP_A[t*NUM_VEC +: NUM_VEC];
    localparam logic [NUM_VEC-1:0] BM = TUP_B[t*NUM_VEC +: NUM_VEC];
    assign vab_d[t] = vab_q[t] | (run & ((h_q & AM) == AM));
    assign vba_d[t] = vba_q[t] | (run & ((h_q & BM) == BM));
    assign tdrv[t]  = ({NUM_VEC{vab_q[t]}} & BM) | ({NUM_VEC{vba_q[t]}} & AM);
  end

  for (genvar e = 0; e < NUM_EQ; e++) begin : g_eq
    localparam logic [NUM_VEC-1:0] EM = EQ_MEMB[e*NUM_VEC +: NUM_VEC];
    assign eq_full[e] = (EM != '0) && ((h_q & EM) == EM);
  end

  always_comb begin
    tup_drv = '0;
    for (int t = 0; t < NUM_TUP; t++) tup_drv |= tdrv[t];
    g_drv = '0;
    for (int g = 0; g < NUM_GUESS; g++)
      if (guess_en[g])
        g_drv |= guess_val[g] ? G_ZERO[g*NUM_VEC +: NUM_VEC] : G_ONE[g*NUM_VEC +: NUM_VEC];
  end

  assign h_d     = h_q | (run ? (tup_drv | g_drv) : '0);
  assign changed = (h_d != h_q) || (vab_d != vab_q) || (vba_d != vba_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0; vab_q <= '0; vba_q <= '0; settled <= 1'b0; steps <= '0;
    end else if (clear) begin
      h_q <= '0; vab_q <= '0; vba_q <= '0; settled <= 1'b0; steps <= '0;
    end else begin
      h_q     <= h_d;
      vab_q   <= vab_d;
      vba_q   <= vba_d;
      settled <= run & ~changed;
      if (changed && (steps != '1)) steps <= steps + STEP_W'(1);
    end
  end

  assign marked       = h_q;
  assign inconsistent = |eq_full;
  assign switch_count = SW_W'(SWITCHES);

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (marked == '0 && steps == '0 && !settled && vab_q == '0 && vba_q == '0));

  a_r6_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (((marked & $past(marked)) == $past(marked)) &&
                ((vab_q & $past(vab_q)) == $past(vab_q)) &&
                ((vba_q & $past(vba_q)) == $past(vba_q))));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> ($stable(marked) && $stable(vab_q) && $stable(vba_q) && $stable(steps)));

  a_r7_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inconsistent) |-> $past(run));

  a_r8_settled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> $stable(marked));

  a_r9_steps_grow: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (steps >= $past(steps)));

endmodule

// File: tb/sim_prop_lattice.sv
`timescale 1ns/1ps
module sim_prop_lattice;
  localparam logic [55:0] RA = 56'h04_02_01_10_08_04_03;
  localparam logic [55:0] RB = 56'h40_80_20_A0_40_10_08;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clear = 1'b0, run = 1'b0, run1 = 1'b0;
  logic [0:0] guess_en = 1'b0, guess_val = 1'b0;
  logic [7:0] marked;
  logic inconsistent, settled;
  logic [7:0] steps;
  logic [6:0] switch_count;
  logic [2:0] marked1;
  logic inconsistent1, settled1;
  logic [7:0] steps1;
  logic [6:0] switch_count1;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  prop_lattice u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .guess_en(guess_en), .guess_val(guess_val), .marked(marked),
    .inconsistent(inconsistent), .settled(settled), .steps(steps),
    .switch_count(switch_count));

  prop_lattice #(
    .NUM_VEC(3), .NUM_EQ(2), .NUM_TUP(2), .NUM_GUESS(1), .STEP_W(8),
    .TUP_A(6'b100_000), .TUP_B(6'b001_100), .EQ_MEMB(6'b100_011),
    .G_ONE(3'b000), .G_ZERO(3'b000)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run1),
    .guess_en(1'b0), .guess_val(1'b0), .marked(marked1),
    .inconsistent(inconsistent1), .settled(settled1), .steps(steps1),
    .switch_count(switch_count1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mark(input logic [7:0] seed);
    logic [7:0] m, a, b;
    bit grew;
    m = seed;
    do begin
      grew = 0;
      for (int t = 0; t < 7; t++) begin
        a = RA[t*8 +: 8];
        b = RB[t*8 +: 8];
        if ((m & a) == a && (m | b) != m) begin m = m | b; grew = 1; end
        if ((m & b) == b && (m | a) != m) begin m = m | a; grew = 1; end
      end
    end while (grew);
    return m;
  endfunction

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; run = 1'b0; run1 = 1'b0; guess_en = 1'b0;
    edges(1);
    clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 marked after reset", marked, 0);
    chk("R1 steps after reset", steps, 0);
    chk("R1 settled after reset", settled, 0);
    chk("R7 inconsistent after reset", inconsistent, 0);
    chk("R10 switch count default", switch_count, 34);
    chk("R10 switch count small", switch_count1, 6);
  endtask

  task automatic t_guess_zero();
    do_clear();
    guess_en = 1'b1; guess_val = 1'b0; run = 1'b1;
    edges(1); chk("R5 guess 0 marks x=1 vector", marked, 8'h08);
    edges(1); chk("R3 verticals only on edge 2", marked, 8'h08);
    edges(1); chk("R2 R4 marks from both vertical roles", marked, 8'h4B);
    edges(1); chk("R7 not yet inconsistent", inconsistent, 0);
    edges(1); chk("R2 edge 5 marks", marked, 8'hEF);
    chk("R7 first equation full", inconsistent, 1);
    edges(3); chk("R8 not settled while changing", settled, 0);
    edges(1); chk("R8 settled", settled, 1);
    chk("R9 steps guess 0", steps, 8);
    chk("R3 reference marking guess 0", marked, ref_mark(8'h08));
  endtask

  task automatic t_guess_one_freeze();
    logic [7:0] snap;
    do_clear();
    chk("R1 clear zeroes marks", marked, 0);
    chk("R1 clear zeroes steps", steps, 0);
    guess_en = 1'b1; guess_val = 1'b1; run = 1'b1;
    edges(1); chk("R5 guess 1 marks x=0 vector", marked, 8'h10);
    edges(2); chk("R4 guess 1 edge 3", marked, 8'hB4);
    snap = marked;
    run = 1'b0;
    edges(3); chk("R6 run low holds marks", marked, snap);
    chk("R6 run low holds steps", steps, 3);
    chk("R8 not settled while idle", settled, 0);
    run = 1'b1;
    edges(6); chk("R3 reference marking guess 1", marked, ref_mark(8'h10));
    chk("R9 steps guess 1", steps, 8);
    chk("R8 settled guess 1", settled, 1);
    chk("R7 inconsistent guess 1", inconsistent, 1);
    guess_val = 1'b0;
    edges(2); chk("R6 marks kept at full", marked, 8'hFF);
  endtask

  task automatic t_no_guess();
    do_clear();
    run = 1'b1; guess_en = 1'b0;
    edges(3);
    chk("R5 disabled guess marks nothing", marked, 0);
    chk("R9 no change no steps", steps, 0);
    chk("R8 settled with no activity", settled, 1);
    chk("R7 no guess consistent", inconsistent, 0);
  endtask

  task automatic t_empty_side();
    do_clear();
    run1 = 1'b1;
    edges(1); chk("R3 empty side fires, no mark yet", marked1, 0);
    edges(1); chk("R3 empty side drives vector", marked1, 3'b100);
    chk("R7 single-vector equation full", inconsistent1, 1);
    edges(2); chk("R4 chained mark", marked1, 3'b101);
    edges(1); chk("R8 still changing edge 5", settled1, 0);
    edges(1); chk("R8 settled small", settled1, 1);
    chk("R9 steps small", steps1, 5);
    chk("R2 undriven vector stays clear", marked1[1], 0);
  endtask

  initial begin
    edges(2);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_guess_zero();
    t_guess_one_freeze();
    t_no_guess();
    t_empty_side();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule